// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multicycle processor datapath. A five-bit micro-program counter selects one word of a 32-entry constant control store. Each word carries twenty datapath control bits and a small sequencing field. The control bits drive the datapath's register loads, mux selects, ALU operation and memory strobes for one clock. The sequencing field picks the next micro-address. The next address can be the following word, an entry point looked up from the instruction's opcode and function code, the fetch word at address 0, or a branch target that is taken when the selected ALU flag is set.

The datapath sits outside the block. The datapath returns the instruction register's opcode and function fields and its zero and carry flags, and the sequencer returns the control bits. All pins are plain level signals sampled on the rising clock edge. The sequencer accepts a new input set on every cycle and never stalls, so there is no valid/ready handshake and no back-pressure path. The control word and the micro-PC are registered together, so the outputs change only at the clock edge.

The micro-program map is fixed. Address 0 fetches and address 1 decodes. Register ALU routines start at 2, 4, 6, 8 and 10, and the load routine occupies 12..14. The store routine occupies 15..16, and branch-on-zero occupies 17..18. The shared branch-taken word is at 19. Branch-on-carry occupies 20..21, and add-immediate occupies 22..23. Addresses 24..31 are empty words that return to fetch.

Top module: `mseq_top`

## Requirements
- R1: Every micro-word lasts exactly one clock, and `ctrl` always equals the control field of the word at address `upc`. Both outputs are registers loaded on the same edge.
- R2: While `rst_n` is low, and on the first cycle after it is released, `upc` is 0 and `ctrl` shows the fetch word. Reset is asynchronous and may arrive in the middle of a routine.
- R3: The fetch word at address 0 asserts memory read, IR load, PC load, ALU-A-from-PC and ALU-B-is-four with ALU op add, and then steps to address 1. The decode word at address 1 asserts only the X and Y loads and then dispatches.
- R4: Sequencing code 00 moves to `upc`+1.
- R5: Sequencing code 01 moves to the entry point given by the opcode and function code. Opcode 0 with function 32/34/36/37/42 maps to 2/4/6/8/10. Opcode 35 maps to 12, 43 to 15, 4 to 17, 6 to 20 and 8 to 22. The opcode and function code have no effect in any other word.
- R6: Sequencing code 10 moves to address 0.
- R7: Sequencing code 11 tests the zero flag when the mode bit is 0 and the carry flag when it is 1. When the tested flag is set, the sequencer jumps to the word's target address; otherwise it moves to `upc`+1. The flag that is not selected is ignored. Both compare words (17, 20) assert flag load with ALU op subtract and target 19. Word 19 asserts PC load and PC-from-branch.
- R8: The load routine runs address-add (result load, ALU-B-immediate) at 12. It then runs memory read into MDR using the result as address (memory read, address-from-result, MDR load) at 13. It then writes the register file from MDR to the rt field (register write, write-data-from-MDR) at 14 and returns to fetch.
- R9: The store routine runs address-add at 15, then memory write using the result as address at 16, and then returns to fetch.
- R10: Each register ALU routine loads the result with ALU op add=0, sub=1, and=2, or=3, slt=4. It then writes the result to the rd field (register write, destination-rd) and returns. Add-immediate runs address-add at 22 and then a register write to rt at 23.
- R11: The control bits are: 0 memory read, 1 memory write, 2 address-from-result, 3 IR load, 4 PC load, 5 PC-from-branch, 6 X load, 7 Y load, 8 result load, 9 MDR load, 10 register write, 11 destination-rd, 12 write-data-from-MDR, 13 ALU-A-from-PC, 14 ALU-B-immediate, 15 ALU-B-is-four, 18:16 ALU op, 19 flag load.
- R12: An opcode/function pair that is not in the R5 map dispatches to address 0.
- R13: Memory read and memory write are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function-code field of the instruction register |
| flag_z | input | 1 | ALU zero flag |
| flag_cy | input | 1 | ALU carry flag |
| ctrl | output | 20 | Registered datapath control bits |
| upc | output | 5 | Registered micro-program counter |

## Verification
The embedded assertions check on every cycle that the increment, return and taken-branch rules move `upc` as stated. They also check that a dispatch on an unmapped code lands on fetch, that reset leaves the sequencer at fetch, and that memory read and write never overlap. The bench's scenarios are the only way to show the content of each routine. These scenarios cover the exact control word at each address and the full dispatch map. They also cover the not-taken branch paths with the opposite flag set, a reset in the middle of a load, and a mapped opcode that is held on the pins outside decode and has no effect.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int CTRL_W     = 20;
  localparam int UPC_W      = 5;
  localparam int ROM_DEPTH  = 1 << UPC_W;
  localparam int OPSEL_W    = 3;

  // control bit positions
  localparam int CB_MRD      = 0;
  localparam int CB_MWR      = 1;
  localparam int CB_ADDR_RES = 2;
  localparam int CB_IR_LD    = 3;
  localparam int CB_PC_LD    = 4;
  localparam int CB_PC_BR    = 5;
  localparam int CB_X_LD     = 6;
  localparam int CB_Y_LD     = 7;
  localparam int CB_RES_LD   = 8;
  localparam int CB_MDR_LD   = 9;
  localparam int CB_RF_WE    = 10;
  localparam int CB_DST_RD   = 11;
  localparam int CB_WB_MDR   = 12;
  localparam int CB_A_PC     = 13;
  localparam int CB_B_IMM    = 14;
  localparam int CB_B_FOUR   = 15;
  localparam int CB_OP_LSB   = 16;
  localparam int CB_FLAG_LD  = 19;

  localparam logic [OPSEL_W-1:0] ALU_ADD = 3'd0;
  localparam logic [OPSEL_W-1:0] ALU_SUB = 3'd1;
  localparam logic [OPSEL_W-1:0] ALU_AND = 3'd2;
  localparam logic [OPSEL_W-1:0] ALU_OR  = 3'd3;
  localparam logic [OPSEL_W-1:0] ALU_SLT = 3'd4;

  // routine entry points
  localparam int EP_FETCH = 0;
  localparam int EP_ADD   = 2;
  localparam int EP_SUB   = 4;
  localparam int EP_AND   = 6;
  localparam int EP_OR    = 8;
  localparam int EP_SLT   = 10;
  localparam int EP_LOAD  = 12;
  localparam int EP_STORE = 15;
  localparam int EP_BEQ   = 17;
  localparam int EP_TAKEN = 19;
  localparam int EP_BCY   = 20;
  localparam int EP_ADDI  = 22;

  typedef enum logic [1:0] {
    SQ_INC  = 2'b00,
    SQ_DISP = 2'b01,
    SQ_RET  = 2'b10,
    SQ_COND = 2'b11
  } seq_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic              m0;
    seq_e              seq;
    logic [UPC_W-1:0]  tgt;
  } uword_t;

  function automatic logic [CTRL_W-1:0] cb(int b);
    return CTRL_W'(1) << b;
  endfunction

  function automatic logic [CTRL_W-1:0] aop(logic [OPSEL_W-1:0] o);
    return CTRL_W'(o) << CB_OP_LSB;
  endfunction

  function automatic uword_t uw(logic [CTRL_W-1:0] c, seq_e s, logic m, int t);
    uword_t w;
    w.ctrl = c;
    w.seq  = s;
    w.m0   = m;
    w.tgt  = UPC_W'(t);
    return w;
  endfunction

  function automatic uword_t rom_word(int a);
    logic [CTRL_W-1:0] exec_c, wb_rd, ea_c, cmp_c;
    exec_c = cb(CB_RES_LD);
    wb_rd  = cb(CB_RF_WE) | cb(CB_DST_RD);
    ea_c   = cb(CB_RES_LD) | cb(CB_B_IMM) | aop(ALU_ADD);
    cmp_c  = cb(CB_FLAG_LD) | aop(ALU_SUB);
    case (a)
      0:  return uw(cb(CB_MRD) | cb(CB_IR_LD) | cb(CB_PC_LD) | cb(CB_A_PC)
                    | cb(CB_B_FOUR) | aop(ALU_ADD), SQ_INC, 1'b0, 0);
      1:  return uw(cb(CB_X_LD) | cb(CB_Y_LD), SQ_DISP, 1'b0, 0);
      2:  return uw(exec_c | aop(ALU_ADD), SQ_INC, 1'b0, 0);
      4:  return uw(exec_c | aop(ALU_SUB), SQ_INC, 1'b0, 0);
      6:  return uw(exec_c | aop(ALU_AND), SQ_INC, 1'b0, 0);
      8:  return uw(exec_c | aop(ALU_OR),  SQ_INC, 1'b0, 0);
      10: return uw(exec_c | aop(ALU_SLT), SQ_INC, 1'b0, 0);
      3, 5, 7, 9, 11: return uw(wb_rd, SQ_RET, 1'b0, 0);
      12, 15, 22: return uw(ea_c, SQ_INC, 1'b0, 0);
      13: return uw(cb(CB_MRD) | cb(CB_ADDR_RES) | cb(CB_MDR_LD), SQ_INC, 1'b0, 0);
      14: return uw(cb(CB_RF_WE) | cb(CB_WB_MDR), SQ_RET, 1'b0, 0);
      16: return uw(cb(CB_MWR) | cb(CB_ADDR_RES), SQ_RET, 1'b0, 0);
      17: return uw(cmp_c, SQ_COND, 1'b0, EP_TAKEN);
      19: return uw(cb(CB_PC_LD) | cb(CB_PC_BR), SQ_RET, 1'b0, 0);
      20: return uw(cmp_c, SQ_COND, 1'b1, EP_TAKEN);
      23: return uw(cb(CB_RF_WE), SQ_RET, 1'b0, 0);
      default: return uw('0, SQ_RET, 1'b0, 0);
    endcase
  endfunction
endpackage

// File: rtl/mseq_dispatch.sv
module mseq_dispatch
  import mseq_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  logic [OP_W-1:0]  opcode,
  input  logic [FN_W-1:0]  funct,
  output logic [UPC_W-1:0] entry,
  output logic             mapped
);
  localparam logic [OP_W-1:0] OPC_REG   = OP_W'(0);
  localparam logic [OP_W-1:0] OPC_BEQ   = OP_W'(4);
  localparam logic [OP_W-1:0] OPC_BCY   = OP_W'(6);
  localparam logic [OP_W-1:0] OPC_ADDI  = OP_W'(8);
  localparam logic [OP_W-1:0] OPC_LOAD  = OP_W'(35);
  localparam logic [OP_W-1:0] OPC_STORE = OP_W'(43);
  localparam logic [FN_W-1:0] FN_ADD = FN_W'(32);
  localparam logic [FN_W-1:0] FN_SUB = FN_W'(34);
  localparam logic [FN_W-1:0] FN_AND = FN_W'(36);
  localparam logic [FN_W-1:0] FN_OR  = FN_W'(37);
  localparam logic [FN_W-1:0] FN_SLT = FN_W'(42);

  logic [UPC_W-1:0] reg_entry;

  always_comb begin
    case (funct)
      FN_ADD:  reg_entry = UPC_W'(EP_ADD);
      FN_SUB:  reg_entry = UPC_W'(EP_SUB);
      FN_AND:  reg_entry = UPC_W'(EP_AND);
      FN_OR:   reg_entry = UPC_W'(EP_OR);
      FN_SLT:  reg_entry = UPC_W'(EP_SLT);
      default: reg_entry = UPC_W'(EP_FETCH);
    endcase
  end

  always_comb begin
    case (opcode)
      OPC_REG:   entry = reg_entry;
      OPC_LOAD:  entry = UPC_W'(EP_LOAD);
      OPC_STORE: entry = UPC_W'(EP_STORE);
      OPC_BEQ:   entry = UPC_W'(EP_BEQ);
      OPC_BCY:   entry = UPC_W'(EP_BCY);
      OPC_ADDI:  entry = UPC_W'(EP_ADDI);
      default:   entry = UPC_W'(EP_FETCH);
    endcase
    mapped = (entry != UPC_W'(EP_FETCH));
  end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
(
  input  logic [UPC_W-1:0] upc,
  input  seq_e             seq,
  input  logic             m0,
  input  logic [UPC_W-1:0] tgt,
  input  logic [UPC_W-1:0] disp_entry,
  input  logic             flag_z,
  input  logic             flag_cy,
  output logic [UPC_W-1:0] next_upc
);
  logic [UPC_W-1:0] inc;
  logic             cond_hit;

  always_comb begin
    inc      = upc + UPC_W'(1);
    cond_hit = m0 ? flag_cy : flag_z;
    case (seq)
      SQ_INC:  next_upc = inc;
      SQ_DISP: next_upc = disp_entry;
      SQ_RET:  next_upc = '0;
      SQ_COND: next_upc = cond_hit ? tgt : inc;
      default: next_upc = '0;
    endcase
  end
endmodule

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
#(
  parameter int DEPTH = ROM_DEPTH
) (
  input  logic [UPC_W-1:0] addr,
  output uword_t           word
);
  uword_t table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign table_w[i] = rom_word(i);
  end

  assign word = table_w[addr];
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode,
  input  logic [FN_W-1:0]   funct,
  input  logic              flag_z,
  input  logic              flag_cy,
  output logic [CTRL_W-1:0] ctrl,
  output logic [UPC_W-1:0]  upc
);
  localparam uword_t RESET_WORD = rom_word(EP_FETCH);

  logic [UPC_W-1:0] upc_q, next_upc, disp_entry;
  logic             disp_mapped;
  uword_t           word_q, word_d;

  mseq_dispatch #(.OP_W(OP_W), .FN_W(FN_W)) u_disp (
    .opcode (opcode),
    .funct  (funct),
    .entry  (disp_entry),
    .mapped (disp_mapped)
  );

  mseq_next u_next (
    .upc        (upc_q),
    .seq        (word_q.seq),
    .m0         (word_q.m0),
    .tgt        (word_q.tgt),
    .disp_entry (disp_entry),
    .flag_z     (flag_z),
    .flag_cy    (flag_cy),
    .next_upc   (next_upc)
  );

  mseq_rom #(.DEPTH(ROM_DEPTH)) u_rom (
    .addr (next_upc),
    .word (word_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q  <= '0;
      word_q <= RESET_WORD;
    end else begin
      upc_q  <= next_upc;
      word_q <= word_d;
    end
  end

  assign ctrl = word_q.ctrl;
  assign upc  = upc_q;

  a_r2_reset_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (upc_q == '0));

  a_r4_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q.seq == SQ_INC) |=> (upc_q == UPC_W'($past(upc_q) + 1)));

  a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q.seq == SQ_RET) |=> (upc_q == '0));

  a_r7_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q.seq == SQ_COND && (word_q.m0 ? flag_cy : flag_z)) |=> (upc_q == $past(word_q.tgt)));

  a_r12_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q.seq == SQ_DISP && !disp_mapped) |=> (upc_q == '0));

  a_r13_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl[CB_MRD], ctrl[CB_MWR]}));
endmodule

// File: tb/sim_mseq_top.sv
`timescale 1ns/1ps
module sim_mseq_top;
  localparam int NPROG = 15;
  localparam int WDOG  = 2000;
  // bit positions per R11
  localparam int MRD = 0, MWR = 1, ARES = 2, IRLD = 3, PCLD = 4, PCBR = 5;
  localparam int XLD = 6, YLD = 7, RESLD = 8, MDRLD = 9, RFWE = 10, DSTRD = 11;
  localparam int WBMDR = 12, APC = 13, BIMM = 14, BFOUR = 15, OPL = 16, FLG = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = 6'd63, funct = 6'd63;
  logic        flag_z = 1'b0, flag_cy = 1'b0;
  logic [19:0] ctrl;
  logic [4:0]  upc;

  always #2.5 clk = ~clk;

  mseq_top u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
    .flag_z(flag_z), .flag_cy(flag_cy), .ctrl(ctrl), .upc(upc)
  );

  int n_cmp = 0, n_bad = 0;
  int p_op[NPROG], p_fn[NPROG];
  bit p_z[NPROG], p_cy[NPROG];

  function automatic logic [19:0] b(int i);
    return 20'(1) << i;
  endfunction

  function automatic logic [19:0] op(int o);
    return 20'(o) << OPL;
  endfunction

  function automatic logic [19:0] exp_ctrl(int u);
    case (u)
      0:  return b(MRD) | b(IRLD) | b(PCLD) | b(APC) | b(BFOUR);
      1:  return b(XLD) | b(YLD);
      2:  return b(RESLD) | op(0);
      4:  return b(RESLD) | op(1);
      6:  return b(RESLD) | op(2);
      8:  return b(RESLD) | op(3);
      10: return b(RESLD) | op(4);
      3, 5, 7, 9, 11: return b(RFWE) | b(DSTRD);
      12, 15, 22: return b(RESLD) | b(BIMM);
      13: return b(MRD) | b(ARES) | b(MDRLD);
      14: return b(RFWE) | b(WBMDR);
      16: return b(MWR) | b(ARES);
      17, 20: return b(FLG) | op(1);
      19: return b(PCLD) | b(PCBR);
      23: return b(RFWE);
      default: return 20'd0;
    endcase
  endfunction

  function automatic int dispatch(int o, int f);
    if (o == 0) begin
      case (f)
        32: return 2;
        34: return 4;
        36: return 6;
        37: return 8;
        42: return 10;
        default: return 0;
      endcase
    end
    case (o)
      35: return 12;
      43: return 15;
      4:  return 17;
      6:  return 20;
      8:  return 22;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_next(int u, int o, int f, bit z, bit cy);
    case (u)
      0: return 1;
      1: return dispatch(o, f);
      2, 4, 6, 8, 10, 12, 13, 15, 22: return u + 1;
      17: return z ? 19 : 18;
      20: return cy ? 19 : 21;
      default: return 0;
    endcase
  endfunction

  function automatic string upc_tag(int prev, bit was_rst, int o, int f);
    if (was_rst) return "R2";
    case (prev)
      0: return "R3";
      1: return (dispatch(o, f) == 0) ? "R12" : "R5";
      17, 20: return "R7";
      2, 4, 6, 8, 10, 12, 13, 15, 22: return "R4";
      default: return "R6";
    endcase
  endfunction

  function automatic string ctrl_tag(int u);
    case (u)
      0: return "R11";
      1: return "R1";
      12, 13, 14: return "R8";
      15, 16: return "R9";
      17, 18, 19, 20, 21: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic compare(int m_upc, string utag);
    logic [19:0] ec;
    ec = exp_ctrl(m_upc);
    check(upc == 5'(m_upc), utag, "upc", int'(upc), m_upc);
    check(ctrl == ec, ctrl_tag(m_upc), "ctrl", int'(ctrl), int'(ec));
    check(!(ctrl[MRD] && ctrl[MWR]), "R13", "rd/wr overlap", int'(ctrl[1:0]), 0);
  endtask

  initial begin
    int idx, m_upc, m_next, cycles, post, cur_op, cur_fn;
    bit did_rst, rst_now;
    string utag;
    // program: R10 ALU ops, R8 load, R9 store, R7 branches, R12 unmapped
    p_op = '{0, 0, 0, 0, 0, 35, 43, 4, 4, 6, 6, 8, 63, 0, 35};
    p_fn = '{32, 34, 36, 37, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    p_z  = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 1, 1, 1, 1, 0};
    p_cy = '{1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 0, 1, 1, 1, 0};
    idx = 0; m_upc = 0; cycles = 0; post = 0; did_rst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(0, "R2");
    rst_n = 1'b1;
    while (post < 3) begin
      rst_now = 1'b0;
      if (m_upc == 1) begin
        if (idx < NPROG) begin
          opcode = 6'(p_op[idx]); funct = 6'(p_fn[idx]);
          flag_z = p_z[idx]; flag_cy = p_cy[idx];
          idx++;
        end else begin
          opcode = 6'd63; funct = 6'd63;
        end
      end else begin
        // R5: a mapped opcode held outside decode must have no effect
        opcode = 6'd35; funct = 6'd32;
      end
      rst_n = 1'b1;
      if (idx == NPROG && m_upc == 13 && !did_rst) begin
        rst_n = 1'b0; rst_now = 1'b1; did_rst = 1'b1;  // R2 mid-routine reset
      end
      cur_op = int'(opcode); cur_fn = int'(funct);
      m_next = rst_now ? 0 : exp_next(m_upc, cur_op, cur_fn, flag_z, flag_cy);
      utag = upc_tag(m_upc, rst_now, cur_op, cur_fn);
      @(posedge clk);
      m_upc = m_next;
      @(negedge clk);
      compare(m_upc, utag);
      cycles++;
      if (did_rst) post++;
      if (cycles >= WDOG) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
        break;
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule